// File: doc/BRIEF.md
# Serial-Shifted Remote RAM Access Bridge

This block lets a compute module that sits behind a narrow link reach a 256-word, 12-bit dual-port RAM on the far side. It does not use dedicated parallel RAM buses. A master controller turns each parallel request into a serial frame and shifts it one bit per clock over a single data line. The frame holds the target address, then a 2-bit command, then (for writes only) the data word. A slave controller rebuilds the frame and drives the RAM ports. For reads, it shifts the 12-bit word back over a second single-bit line.

Both controllers and the RAM run on one shared clock, so nothing crosses a clock domain. The serial lines are assumed to be free of ordinary module traffic whenever a RAM command is in flight. A clear command makes the slave sweep every RAM word to zero, one address per cycle. The master reports the whole transaction as busy until the sweep ends.

Top module: `srb_bridge`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done` and `sweep_busy` are low and `rdata` is zero.
- R2: The command encoding is 00 idle, 01 read, 10 write, 11 clear. The idle code offered to an idle master starts nothing and leaves `busy` low.
- R3: A write accepted at a clock edge keeps `busy` high for 22 edges. It falls at the 22nd edge after the accepting edge, and the word is stored at the addressed location.
- R4: A read accepted at a clock edge raises `done` for exactly one cycle at the 24th edge after the accepting edge. At that edge `rdata` carries the stored 12-bit word and `busy` falls.
- R5: A clear command zeroes all 256 words. `sweep_busy` rises at the 10th edge and falls at the 266th edge after the accepting edge, and `busy` falls at the 267th edge.
- R6: Commands offered while `busy` is high are ignored. They change neither the RAM contents nor `rdata`.
- R7: A frame sends the address most-significant bit first, then the 2-bit command most-significant bit first, then, for writes, the 12 data bits most-significant bit first. Distinct addresses and data words therefore round-trip intact.
- R8: The serial line from master to slave is quiet whenever the master is not busy. A frame starts only at the edge after a non-idle command was accepted, and its first bit is the top address bit.
- R9: `rdata` changes only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for master, slave and RAM |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2 | Command: 00 idle, 01 read, 10 write, 11 clear |
| req_addr | input | 8 | Target word address |
| req_wdata | input | 12 | Word to be written |
| busy | output | 1 | Transaction in progress; new commands ignored |
| done | output | 1 | One-cycle pulse when read data is returned |
| rdata | output | 12 | Most recent word returned by a read |
| sweep_busy | output | 1 | Slave is clearing the RAM |

## Verification
The completion of a read (the `done` pulse with `busy` falling) and the arrival of the next command can fall in the same cycle. The bench provokes this by holding a read command without a break through two completions. A behavioural timeline model predicts acceptance on the edge after `done`, with a 25-cycle spacing between the pulses. The outputs are compared against that model every cycle. Commands that change while a write is being shifted, and a clear that follows stored data, are judged the same way: read-back values are checked against what the requirements say must have been kept.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int OPW = 2;

  typedef enum logic [OPW-1:0] {
    OP_NOP = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_CLR = 2'b11
  } srb_op_e;
endpackage

// File: rtl/srb_dpram.sv
module srb_dpram #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Registered read, separate write port: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/srb_master.sv
module srb_master
  import srb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] req_op,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic           sl_sweep,
  output logic           m2s_vld,
  output logic           m2s_bit,
  input  logic           s2m_vld,
  input  logic           s2m_bit,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  rdata
);
  localparam int FW  = AW + OPW + DW;
  localparam int CW  = $clog2(FW + 1);
  localparam int RCW = $clog2(DW);
  localparam logic [CW-1:0]  LEN_WR   = CW'(FW);
  localparam logic [CW-1:0]  LEN_SH   = CW'(AW + OPW);
  localparam logic [RCW-1:0] RX_LAST  = RCW'(DW - 1);

  typedef enum logic [1:0] {M_IDLE, M_SEND, M_RX, M_CLR} mst_e;

  mst_e          state;
  logic [FW-1:0] tx_sr;
  logic [CW-1:0] left;
  srb_op_e       op_q;
  logic [DW-1:0] rx_sr;
  logic [RCW-1:0] rx_cnt;

  assign m2s_bit = tx_sr[FW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= M_IDLE;
      tx_sr   <= '0;
      left    <= '0;
      op_q    <= OP_NOP;
      rx_sr   <= '0;
      rx_cnt  <= '0;
      m2s_vld <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        M_IDLE: begin
          if (req_op != OP_NOP) begin
            tx_sr   <= {req_addr, req_op, (req_op == OP_WR) ? req_wdata : {DW{1'b0}}};
            left    <= (req_op == OP_WR) ? LEN_WR : LEN_SH;
            op_q    <= srb_op_e'(req_op);
            m2s_vld <= 1'b1;
            busy    <= 1'b1;
            state   <= M_SEND;
          end
        end
        M_SEND: begin
          tx_sr <= tx_sr << 1;
          left  <= left - 1'b1;
          if (left == CW'(1)) begin
            m2s_vld <= 1'b0;
            unique case (op_q)
              OP_WR: begin
                busy  <= 1'b0;
                state <= M_IDLE;
              end
              OP_RD: begin
                rx_cnt <= '0;
                state  <= M_RX;
              end
              default: state <= M_CLR;
            endcase
          end
        end
        M_RX: begin
          if (s2m_vld) begin
            if (rx_cnt == RX_LAST) begin
              rdata <= {rx_sr[DW-2:0], s2m_bit};
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= M_IDLE;
            end else begin
              rx_sr  <= {rx_sr[DW-2:0], s2m_bit};
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
        end
        M_CLR: begin
          if (!sl_sweep) begin
            busy  <= 1'b0;
            state <= M_IDLE;
          end
        end
        default: state <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srb_slave.sv
module srb_slave
  import srb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m2s_vld,
  input  logic          m2s_bit,
  output logic          s2m_vld,
  output logic          s2m_bit,
  output logic          sweep,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] ram_raddr,
  input  logic [DW-1:0] ram_q
);
  localparam int FW  = AW + OPW + DW;
  localparam int CW  = $clog2(FW + 1);
  localparam int TCW = $clog2(DW);
  localparam logic [CW-1:0]  HDR_LAST = CW'(AW + OPW - 1);
  localparam logic [CW-1:0]  FRM_LAST = CW'(FW - 1);
  localparam logic [TCW-1:0] TX_LAST  = TCW'(DW - 1);

  typedef enum logic [2:0] {S_RECV, S_RD1, S_RD2, S_TX, S_SWEEP} slv_e;

  slv_e           state;
  logic [FW-1:0]  rx_sr;
  logic [CW-1:0]  rx_cnt;
  logic [DW-1:0]  tx_sr;
  logic [TCW-1:0] tx_cnt;
  logic [AW-1:0]  sw_cnt;
  logic           wr_pend;
  logic [AW-1:0]  wa;
  logic [DW-1:0]  wd;
  logic [AW-1:0]  ra;
  srb_op_e        hdr_op;

  // Command as it completes: previous bit plus the one on the line now.
  assign hdr_op  = srb_op_e'({rx_sr[0], m2s_bit});
  assign s2m_bit = tx_sr[DW-1];

  assign ram_we    = wr_pend | sweep;
  assign ram_waddr = sweep ? sw_cnt : wa;
  assign ram_wdata = sweep ? {DW{1'b0}} : wd;
  assign ram_raddr = ra;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_RECV;
      rx_sr   <= '0;
      rx_cnt  <= '0;
      tx_sr   <= '0;
      tx_cnt  <= '0;
      sw_cnt  <= '0;
      wr_pend <= 1'b0;
      wa      <= '0;
      wd      <= '0;
      ra      <= '0;
      sweep   <= 1'b0;
      s2m_vld <= 1'b0;
    end else begin
      wr_pend <= 1'b0;
      unique case (state)
        S_RECV: begin
          if (m2s_vld) begin
            rx_sr  <= {rx_sr[FW-2:0], m2s_bit};
            rx_cnt <= rx_cnt + 1'b1;
            if (rx_cnt == HDR_LAST) begin
              if (hdr_op == OP_RD) begin
                ra     <= rx_sr[AW:1];
                rx_cnt <= '0;
                state  <= S_RD1;
              end else if (hdr_op == OP_CLR) begin
                sw_cnt <= '0;
                sweep  <= 1'b1;
                rx_cnt <= '0;
                state  <= S_SWEEP;
              end
            end
            if (rx_cnt == FRM_LAST) begin
              wa      <= rx_sr[FW-2 -: AW];
              wd      <= {rx_sr[DW-2:0], m2s_bit};
              wr_pend <= 1'b1;
              rx_cnt  <= '0;
            end
          end
        end
        S_RD1: state <= S_RD2;
        S_RD2: begin
          tx_sr   <= ram_q;
          tx_cnt  <= '0;
          s2m_vld <= 1'b1;
          state   <= S_TX;
        end
        S_TX: begin
          tx_sr  <= tx_sr << 1;
          tx_cnt <= tx_cnt + 1'b1;
          if (tx_cnt == TX_LAST) begin
            s2m_vld <= 1'b0;
            state   <= S_RECV;
          end
        end
        S_SWEEP: begin
          sw_cnt <= sw_cnt + 1'b1;
          if (sw_cnt == {AW{1'b1}}) begin
            sweep <= 1'b0;
            state <= S_RECV;
          end
        end
        default: state <= S_RECV;
      endcase
    end
  end
endmodule

// File: rtl/srb_bridge.sv
module srb_bridge
  import srb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] req_op,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  rdata,
  output logic           sweep_busy
);
  logic          m2s_vld;
  logic          m2s_bit;
  logic          s2m_vld;
  logic          s2m_bit;
  logic          sweep;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [DW-1:0] ram_wdata;
  logic [AW-1:0] ram_raddr;
  logic [DW-1:0] ram_q;

  assign sweep_busy = sweep;

  srb_master #(.AW(AW), .DW(DW)) u_master (
    .clk      (clk),
    .rst      (rst),
    .req_op   (req_op),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .sl_sweep (sweep),
    .m2s_vld  (m2s_vld),
    .m2s_bit  (m2s_bit),
    .s2m_vld  (s2m_vld),
    .s2m_bit  (s2m_bit),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata)
  );

  srb_slave #(.AW(AW), .DW(DW)) u_slave (
    .clk      (clk),
    .rst      (rst),
    .m2s_vld  (m2s_vld),
    .m2s_bit  (m2s_bit),
    .s2m_vld  (s2m_vld),
    .s2m_bit  (s2m_bit),
    .sweep    (sweep),
    .ram_we   (ram_we),
    .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr),
    .ram_q    (ram_q)
  );

  srb_dpram #(.AW(AW), .DW(DW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(ram_raddr),
    .q    (ram_q)
  );
endmodule

// File: rtl/srb_chk.sv
module srb_chk #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rdata,
  input logic          sweep_busy,
  input logic          m2s_vld,
  input logic          m2s_bit
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !sweep_busy && rdata == '0));

  p_nop_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_op == 2'b00) |=> !busy);

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_sweep_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
    sweep_busy |-> busy);

  p_busy_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && sweep_busy) |=> busy);

  p_frame_first_bit_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(m2s_vld) |-> (m2s_bit == $past(req_addr[AW-1])));

  p_link_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !m2s_vld);

  p_frame_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(m2s_vld) |-> ($past(req_op) != 2'b00 && !$past(busy)));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata));
endmodule

bind srb_bridge srb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .busy      (busy),
  .done      (done),
  .rdata     (rdata),
  .sweep_busy(sweep_busy),
  .m2s_vld   (m2s_vld),
  .m2s_bit   (m2s_bit)
);

// File: tb/srb_bridge_tb.sv
module srb_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  req_op = 2'b00;
  logic [7:0]  req_addr = '0;
  logic [11:0] req_wdata = '0;
  logic        busy, done, sweep_busy;
  logic [11:0] rdata;

  int nchk = 0;
  int nfail = 0;

  // Reference timeline model
  int mem [256];
  int m_busy = 0, m_done = 0, m_sweep = 0, m_rdata = 0;
  int m_kind = 0, m_k = 0, m_val = 0;

  always #5 clk = ~clk;

  srb_bridge u_dut (
    .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .sweep_busy(sweep_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_sweep = 0; m_rdata = 0; m_k = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        m_k++;
        if (m_kind == 2 && m_k == 22) m_busy = 0;
        if (m_kind == 1 && m_k == 24) begin
          m_busy = 0; m_done = 1; m_rdata = m_val;
        end
        if (m_kind == 3) begin
          if (m_k == 10)  m_sweep = 1;
          if (m_k == 266) m_sweep = 0;
          if (m_k == 267) m_busy = 0;
        end
      end else if (req_op != 2'b00) begin
        m_busy = 1; m_k = 0; m_kind = int'(req_op);
        if (req_op == 2'b10) mem[req_addr] = int'(req_wdata);
        if (req_op == 2'b01) m_val = mem[req_addr];
        if (req_op == 2'b11) for (int i = 0; i < 256; i++) mem[i] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 busy vs model", int'(busy), m_busy);
      chk("R4 done vs model", int'(done), m_done);
      chk("R5 sweep_busy vs model", int'(sweep_busy), m_sweep);
      chk("R9 rdata vs model", int'(rdata), m_rdata);
    end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [11:0] d);
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_op = 2'b00;
    while (busy) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output int got);
    @(negedge clk);
    req_op = 2'b01; req_addr = a;
    @(negedge clk);
    req_op = 2'b00;
    while (!done) @(negedge clk);
    got = int'(rdata);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int got;
    int t0;
    int t1;
    int pulses;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 sweep_busy", int'(sweep_busy), 0);
    chk("R1 rdata", int'(rdata), 0);

    // R2 idle code does nothing
    req_op = 2'b00; req_addr = 8'h33; req_wdata = 12'h999;
    repeat (6) @(negedge clk);
    chk("R2 idle code ignored", int'(busy), 0);

    // R5 clear the RAM first
    issue(2'b11, 8'h00, 12'h000);
    rd(8'h00, got);  chk("R5 word 0 cleared", got, 0);
    rd(8'hFF, got);  chk("R5 word 255 cleared", got, 0);

    // R3 / R7 writes and read-back with distinct patterns
    issue(2'b10, 8'hA5, 12'h123);
    issue(2'b10, 8'h5A, 12'hABC);
    issue(2'b10, 8'hFF, 12'hFFF);
    issue(2'b10, 8'h00, 12'h001);
    rd(8'hA5, got);  chk("R7 addr A5 order", got, 12'h123);
    rd(8'h5A, got);  chk("R7 addr 5A order", got, 12'hABC);
    rd(8'hFF, got);  chk("R3 all-ones word", got, 12'hFFF);
    rd(8'h00, got);  chk("R3 low address", got, 12'h001);

    // R6 command changed while busy is ignored
    @(negedge clk);
    req_op = 2'b10; req_addr = 8'h10; req_wdata = 12'h777;
    @(negedge clk);
    req_op = 2'b10; req_addr = 8'h20; req_wdata = 12'h555;
    repeat (15) @(negedge clk);
    chk("R6 still busy", int'(busy), 1);
    req_op = 2'b00;
    while (busy) @(negedge clk);
    rd(8'h20, got);  chk("R6 ignored write absent", got, 0);
    rd(8'h10, got);  chk("R3 accepted write", got, 12'h777);

    // R4 read held through completion: re-accepted the edge after done
    @(negedge clk);
    req_op = 2'b01; req_addr = 8'hA5;
    pulses = 0; t0 = 0; t1 = 0;
    while (pulses < 2) begin
      @(negedge clk);
      if (done) begin
        pulses++;
        if (pulses == 1) t0 = int'($time / 10);
        else begin
          t1 = int'($time / 10);
          req_op = 2'b00;
        end
        chk("R4 back-to-back data", int'(rdata), 12'h123);
      end
    end
    chk("R4 done spacing", t1 - t0, 25);

    // R5 clear after data
    issue(2'b11, 8'h77, 12'h000);
    rd(8'hA5, got);  chk("R5 cleared after data", got, 0);
    rd(8'h10, got);  chk("R5 cleared second word", got, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule